// File: doc/BRIEF.md
# Split Transaction Descriptor Updater

This block revises the control and status fields of one bulk split-transaction descriptor after each bus transaction attempt. The scheduler presents the descriptor's current fields on the input ports and pulses `done_i` for one cycle with an outcome code. One clock later the block shows the revised fields on registered outputs and raises `upd_o` for one cycle. Alongside the fields it gives the index of the descriptor to visit next: the following slot, or a linked slot when the descriptor asks for a jump.

Two retry budgets decide when a descriptor is retired. An error budget counts down on missing or corrupt responses and is refilled by any flow-control handshake (NAK or NYET). A NAK budget counts down on each NAK, but only when its programmed reload value is nonzero. A babble outcome retires the descriptor at once. An acknowledged start split moves the descriptor to its complete-split phase. An acknowledged complete split flips the data toggle and retires the descriptor.

Control is a two-state machine. `ST_IDLE` is the resting state. `ST_REPORT` is the cycle in which `upd_o` is high. Transition `T_ACCEPT` enters `ST_REPORT` from either state whenever a pulse arrives with the valid input set. Transition `T_RELEASE` returns to `ST_IDLE` when no such pulse arrives.

Top module: `spl_desc_updater`

## Requirements
- R1: After reset, `upd_o` is 0 and every registered output field, including `q_next`, is 0.
- R2: A pulse on `done_i` with `d_valid`=1 makes `upd_o` high in exactly the following cycle. `upd_o` is low in every other cycle.
- R3: A pulse on `done_i` with `d_valid`=0 is ignored. `upd_o` stays 0 and all outputs hold their previous values.
- R4: Outcome ACK (code 0) with `d_phase`=0 (start split) sets `q_phase` to 1 (complete split). Toggle, valid and active are unchanged.
- R5: Outcome ACK with `d_phase`=1 inverts the data toggle and clears `q_valid` and `q_active`.
- R6: Outcome XERR (code 3, no or bad response) decrements the error budget, stopping at 0. When the new value is 0, `q_valid` and `q_active` clear and `q_xerr` and `q_halt` set.
- R7: Outcomes NAK (code 1) and NYET (code 2) reload the error budget to all ones (3 at the default width).
- R8: Outcome NAK with `d_nak_reload` nonzero decrements the NAK budget, stopping at 0. When the new value is 0, `q_valid` and `q_active` clear.
- R9: Outcome NAK with `d_nak_reload`=0 leaves the NAK budget and the valid bit unchanged.
- R10: Outcome BABBLE (code 4) sets `q_babble` and clears `q_valid` and `q_active`.
- R11: With `d_jump`=0, `q_next` is `d_idx`+1 modulo 32. With `d_jump`=1, `q_next` is `d_link`.
- R12: Accepted pulses on consecutive cycles each produce their own update, and `upd_o` stays high for each of them.
- R13: Outcome codes 5 to 7 still produce an update, but all status fields pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| done_i | input | 1 | One-cycle completion pulse |
| outcome_i | input | 3 | Outcome: 0 ACK, 1 NAK, 2 NYET, 3 XERR, 4 BABBLE |
| d_valid | input | 1 | Descriptor valid |
| d_active | input | 1 | Descriptor active |
| d_halt | input | 1 | Halt flag |
| d_babble | input | 1 | Babble flag |
| d_xerr | input | 1 | Transaction-error flag |
| d_phase | input | 1 | 0 start split, 1 complete split |
| d_toggle | input | 1 | Data toggle |
| d_err_left | input | 2 | Error budget |
| d_nak_left | input | 4 | NAK budget |
| d_nak_reload | input | 4 | Programmed NAK reload value |
| d_jump | input | 1 | 1 selects the link field as the next index |
| d_link | input | 5 | Linked descriptor index |
| d_idx | input | 5 | Current descriptor index |
| upd_o | output | 1 | Update valid, one cycle |
| q_valid | output | 1 | Revised valid |
| q_active | output | 1 | Revised active |
| q_halt | output | 1 | Revised halt |
| q_babble | output | 1 | Revised babble |
| q_xerr | output | 1 | Revised transaction error |
| q_phase | output | 1 | Revised phase |
| q_toggle | output | 1 | Revised data toggle |
| q_err_left | output | 2 | Revised error budget |
| q_nak_left | output | 4 | Revised NAK budget |
| q_next | output | 5 | Next descriptor index |

## Verification
The main function is driven from a vector table. It covers each outcome code against start and complete phases, both data-toggle values, error budgets of 3, 1 and 0, and NAK budgets with zero and nonzero reload. These cases tell an ordinary decrement apart from a retirement, and a counting NAK apart from a non-counting one. The index rows separate plain stepping, the wrap from 31 to 0, and the jump to a link. Directed cases then cover the reset values, a pulse with the valid input low, back-to-back pulses, and the quiet cycle after an update.

// File: rtl/spl_pkg.sv
package spl_pkg;

    typedef enum logic [2:0] {
        OC_ACK    = 3'd0,
        OC_NAK    = 3'd1,
        OC_NYET   = 3'd2,
        OC_XERR   = 3'd3,
        OC_BABBLE = 3'd4
    } outcome_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } upd_state_e;

endpackage

// File: rtl/spl_err_ctr.sv
module spl_err_ctr #(
    parameter int ERR_W = 2
) (
    input  logic [2:0]       outcome,
    input  logic [ERR_W-1:0] err_in,
    output logic [ERR_W-1:0] err_out,
    output logic             exhausted
);
    import spl_pkg::*;

    localparam logic [ERR_W-1:0] ERR_FULL = '1;

    always_comb begin
        err_out   = err_in;
        exhausted = 1'b0;
        case (outcome)
            OC_NAK, OC_NYET: err_out = ERR_FULL;
            OC_XERR: begin
                err_out   = (err_in == '0) ? '0 : err_in - ERR_W'(1);
                exhausted = (err_out == '0);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/spl_nak_ctr.sv
module spl_nak_ctr #(
    parameter int NAK_W = 4
) (
    input  logic [2:0]       outcome,
    input  logic [NAK_W-1:0] nak_in,
    input  logic [NAK_W-1:0] nak_reload,
    output logic [NAK_W-1:0] nak_out,
    output logic             exhausted
);
    import spl_pkg::*;

    logic counting;

    assign counting = (outcome == OC_NAK) && (nak_reload != '0);

    always_comb begin
        nak_out   = nak_in;
        exhausted = 1'b0;
        if (counting) begin
            nak_out   = (nak_in == '0) ? '0 : nak_in - NAK_W'(1);
            exhausted = (nak_out == '0);
        end
    end
endmodule

// File: rtl/spl_next_sel.sv
module spl_next_sel #(
    parameter int IDX_W = 5
) (
    input  logic             jump,
    input  logic [IDX_W-1:0] link,
    input  logic [IDX_W-1:0] idx,
    output logic [IDX_W-1:0] next_idx
);
    always_comb begin
        if (jump) next_idx = link;
        else      next_idx = idx + IDX_W'(1);
    end
endmodule

// File: rtl/spl_desc_updater.sv
module spl_desc_updater #(
    parameter int ERR_W = 2,
    parameter int NAK_W = 4,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done_i,
    input  logic [2:0]       outcome_i,
    input  logic             d_valid,
    input  logic             d_active,
    input  logic             d_halt,
    input  logic             d_babble,
    input  logic             d_xerr,
    input  logic             d_phase,
    input  logic             d_toggle,
    input  logic [ERR_W-1:0] d_err_left,
    input  logic [NAK_W-1:0] d_nak_left,
    input  logic [NAK_W-1:0] d_nak_reload,
    input  logic             d_jump,
    input  logic [IDX_W-1:0] d_link,
    input  logic [IDX_W-1:0] d_idx,
    output logic             upd_o,
    output logic             q_valid,
    output logic             q_active,
    output logic             q_halt,
    output logic             q_babble,
    output logic             q_xerr,
    output logic             q_phase,
    output logic             q_toggle,
    output logic [ERR_W-1:0] q_err_left,
    output logic [NAK_W-1:0] q_nak_left,
    output logic [IDX_W-1:0] q_next
);
    import spl_pkg::*;

    upd_state_e       state_q, state_d;
    logic             accept;
    logic [ERR_W-1:0] err_nx;
    logic             err_exh;
    logic [NAK_W-1:0] nak_nx;
    logic             nak_exh;
    logic [IDX_W-1:0] idx_nx;
    logic             r_valid, r_active, r_halt, r_babble, r_xerr, r_phase, r_toggle;

    assign accept = done_i && d_valid;

    spl_err_ctr #(.ERR_W(ERR_W)) u_err (
        .outcome   (outcome_i),
        .err_in    (d_err_left),
        .err_out   (err_nx),
        .exhausted (err_exh)
    );

    spl_nak_ctr #(.NAK_W(NAK_W)) u_nak (
        .outcome    (outcome_i),
        .nak_in     (d_nak_left),
        .nak_reload (d_nak_reload),
        .nak_out    (nak_nx),
        .exhausted  (nak_exh)
    );

    spl_next_sel #(.IDX_W(IDX_W)) u_next (
        .jump     (d_jump),
        .link     (d_link),
        .idx      (d_idx),
        .next_idx (idx_nx)
    );

    // Revised flag bits for the presented outcome
    always_comb begin
        r_valid  = d_valid;
        r_active = d_active;
        r_halt   = d_halt;
        r_babble = d_babble;
        r_xerr   = d_xerr;
        r_phase  = d_phase;
        r_toggle = d_toggle;
        case (outcome_i)
            OC_ACK: begin
                if (!d_phase) begin
                    r_phase = 1'b1;
                end else begin
                    r_toggle = ~d_toggle;
                    r_valid  = 1'b0;
                    r_active = 1'b0;
                end
            end
            OC_NAK: begin
                if (nak_exh) begin
                    r_valid  = 1'b0;
                    r_active = 1'b0;
                end
            end
            OC_XERR: begin
                if (err_exh) begin
                    r_valid  = 1'b0;
                    r_active = 1'b0;
                    r_xerr   = 1'b1;
                    r_halt   = 1'b1;
                end
            end
            OC_BABBLE: begin
                r_babble = 1'b1;
                r_valid  = 1'b0;
                r_active = 1'b0;
            end
            default: ;
        endcase
    end

    // Next-state logic: T_ACCEPT / T_RELEASE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = accept ? ST_REPORT : ST_IDLE;
            ST_REPORT: state_d = accept ? ST_REPORT : ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign upd_o = (state_q == ST_REPORT);

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid    <= 1'b0;
            q_active   <= 1'b0;
            q_halt     <= 1'b0;
            q_babble   <= 1'b0;
            q_xerr     <= 1'b0;
            q_phase    <= 1'b0;
            q_toggle   <= 1'b0;
            q_err_left <= '0;
            q_nak_left <= '0;
            q_next     <= '0;
        end else if (accept) begin
            q_valid    <= r_valid;
            q_active   <= r_active;
            q_halt     <= r_halt;
            q_babble   <= r_babble;
            q_xerr     <= r_xerr;
            q_phase    <= r_phase;
            q_toggle   <= r_toggle;
            q_err_left <= err_nx;
            q_nak_left <= nak_nx;
            q_next     <= idx_nx;
        end
    end
endmodule

// File: rtl/spl_desc_updater_chk.sv
module spl_desc_updater_chk #(
    parameter int ERR_W = 2,
    parameter int IDX_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             done_i,
    input logic [2:0]       outcome_i,
    input logic             d_valid,
    input logic [ERR_W-1:0] d_err_left,
    input logic             d_jump,
    input logic [IDX_W-1:0] d_link,
    input logic [IDX_W-1:0] d_idx,
    input logic             upd_o,
    input logic             q_valid,
    input logic             q_active,
    input logic             q_halt,
    input logic             q_babble,
    input logic             q_xerr,
    input logic [ERR_W-1:0] q_err_left,
    input logic [IDX_W-1:0] q_next
);
    logic acc;
    assign acc = done_i && d_valid;

    AST_UPD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) acc |=> upd_o); // R2
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n) !acc |=> !upd_o); // R2
    AST_IGNORE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !d_valid) |=> ($stable(q_valid) && $stable(q_next) && $stable(q_err_left))); // R3
    AST_XERR_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && outcome_i == 3'd3 && d_err_left <= ERR_W'(1)) |=> (!q_valid && !q_active && q_xerr && q_halt)); // R6
    AST_ERR_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && (outcome_i == 3'd1 || outcome_i == 3'd2)) |=> (q_err_left == '1)); // R7
    AST_BABBLE_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && outcome_i == 3'd4) |=> (q_babble && !q_valid && !q_active)); // R10
    AST_NEXT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !d_jump) |=> (q_next == IDX_W'($past(d_idx) + IDX_W'(1)))); // R11
    AST_NEXT_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && d_jump) |=> (q_next == $past(d_link))); // R11
endmodule

bind spl_desc_updater spl_desc_updater_chk #(.ERR_W(ERR_W), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .done_i     (done_i),
    .outcome_i  (outcome_i),
    .d_valid    (d_valid),
    .d_err_left (d_err_left),
    .d_jump     (d_jump),
    .d_link     (d_link),
    .d_idx      (d_idx),
    .upd_o      (upd_o),
    .q_valid    (q_valid),
    .q_active   (q_active),
    .q_halt     (q_halt),
    .q_babble   (q_babble),
    .q_xerr     (q_xerr),
    .q_err_left (q_err_left),
    .q_next     (q_next)
);

// File: tb/spl_desc_updater_test.sv
module spl_desc_updater_test;

    typedef struct packed {
        logic [3:0] rq;
        logic [2:0] oc;
        logic       ph;
        logic       tg;
        logic [1:0] er;
        logic [3:0] nk;
        logic [3:0] rl;
        logic       jp;
        logic [4:0] lk;
        logic [4:0] ix;
        logic       ev;
        logic       ea;
        logic       eh;
        logic       eb;
        logic       ex;
        logic       eph;
        logic       etg;
        logic [1:0] eer;
        logic [3:0] enk;
        logic [4:0] enx;
    } vec_t;

    localparam int NV = 13;
    // rq oc ph tg er nk rl jp lk ix | ev ea eh eb ex eph etg eer enk enx
    localparam vec_t VECS [NV] = '{
        '{4'd4,  3'd0, 1'b0, 1'b0, 2'd3, 4'd5, 4'd5, 1'b0, 5'd0,  5'd3,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd3, 4'd5, 5'd4},  // R4
        '{4'd5,  3'd0, 1'b1, 1'b0, 2'd2, 4'd5, 4'd5, 1'b0, 5'd0,  5'd31, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'd2, 4'd5, 5'd0},  // R5 R11 wrap
        '{4'd5,  3'd0, 1'b1, 1'b1, 2'd2, 4'd5, 4'd5, 1'b1, 5'd9,  5'd2,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd2, 4'd5, 5'd9},  // R5 R11 jump
        '{4'd6,  3'd3, 1'b0, 1'b0, 2'd3, 4'd5, 4'd5, 1'b0, 5'd0,  5'd7,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 4'd5, 5'd8},  // R6
        '{4'd6,  3'd3, 1'b1, 1'b0, 2'd1, 4'd5, 4'd5, 1'b0, 5'd0,  5'd7,  1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 4'd5, 5'd8},  // R6
        '{4'd6,  3'd3, 1'b0, 1'b1, 2'd0, 4'd5, 4'd5, 1'b1, 5'd17, 5'd7,  1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'd0, 4'd5, 5'd17}, // R6
        '{4'd7,  3'd1, 1'b0, 1'b0, 2'd1, 4'd5, 4'd5, 1'b0, 5'd0,  5'd10, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 4'd4, 5'd11}, // R7 R8
        '{4'd8,  3'd1, 1'b1, 1'b0, 2'd2, 4'd1, 4'd5, 1'b0, 5'd0,  5'd10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd3, 4'd0, 5'd11}, // R8
        '{4'd9,  3'd1, 1'b0, 1'b0, 2'd2, 4'd0, 4'd0, 1'b0, 5'd0,  5'd12, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 4'd0, 5'd13}, // R9
        '{4'd9,  3'd1, 1'b0, 1'b0, 2'd2, 4'd7, 4'd0, 1'b0, 5'd0,  5'd12, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 4'd7, 5'd13}, // R9
        '{4'd7,  3'd2, 1'b1, 1'b0, 2'd0, 4'd2, 4'd3, 1'b0, 5'd0,  5'd20, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd3, 4'd2, 5'd21}, // R7 NYET
        '{4'd10, 3'd4, 1'b0, 1'b1, 2'd3, 4'd5, 4'd5, 1'b0, 5'd0,  5'd1,  1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'd3, 4'd5, 5'd2},  // R10
        '{4'd13, 3'd6, 1'b1, 1'b1, 2'd1, 4'd6, 4'd2, 1'b0, 5'd0,  5'd5,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'd1, 4'd6, 5'd6}   // R13
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       done_i = 1'b0;
    logic [2:0] outcome_i = '0;
    logic       d_valid = 1'b0, d_active = 1'b0, d_halt = 1'b0, d_babble = 1'b0;
    logic       d_xerr = 1'b0, d_phase = 1'b0, d_toggle = 1'b0, d_jump = 1'b0;
    logic [1:0] d_err_left = '0;
    logic [3:0] d_nak_left = '0, d_nak_reload = '0;
    logic [4:0] d_link = '0, d_idx = '0;
    logic       upd_o, q_valid, q_active, q_halt, q_babble, q_xerr, q_phase, q_toggle;
    logic [1:0] q_err_left;
    logic [3:0] q_nak_left;
    logic [4:0] q_next;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    spl_desc_updater uut (
        .clk(clk), .rst_n(rst_n), .done_i(done_i), .outcome_i(outcome_i),
        .d_valid(d_valid), .d_active(d_active), .d_halt(d_halt), .d_babble(d_babble),
        .d_xerr(d_xerr), .d_phase(d_phase), .d_toggle(d_toggle), .d_err_left(d_err_left),
        .d_nak_left(d_nak_left), .d_nak_reload(d_nak_reload), .d_jump(d_jump),
        .d_link(d_link), .d_idx(d_idx), .upd_o(upd_o), .q_valid(q_valid),
        .q_active(q_active), .q_halt(q_halt), .q_babble(q_babble), .q_xerr(q_xerr),
        .q_phase(q_phase), .q_toggle(q_toggle), .q_err_left(q_err_left),
        .q_nak_left(q_nak_left), .q_next(q_next)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply_vec(input vec_t v);
        outcome_i = v.oc; d_valid = 1'b1; d_active = 1'b1; d_halt = 1'b0;
        d_babble = 1'b0; d_xerr = 1'b0; d_phase = v.ph; d_toggle = v.tg;
        d_err_left = v.er; d_nak_left = v.nk; d_nak_reload = v.rl;
        d_jump = v.jp; d_link = v.lk; d_idx = v.ix;
    endtask

    function automatic int pack_q();
        return {q_valid, q_active, q_halt, q_babble, q_xerr, q_phase, q_toggle,
                q_err_left, q_nak_left, q_next};
    endfunction

    function automatic int pack_e(input vec_t v);
        return {v.ev, v.ea, v.eh, v.eb, v.ex, v.eph, v.etg, v.eer, v.enk, v.enx};
    endfunction

    initial begin
        int held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 upd_o", int'(upd_o), 0);
        check("R1 fields", pack_q(), 0);

        // Table walk: pulse one cycle, sample at the next falling edge
        for (int i = 0; i < NV; i++) begin
            apply_vec(VECS[i]);
            done_i = 1'b1;
            @(negedge clk);
            done_i = 1'b0;
            check($sformatf("R2 upd_o row %0d", i), int'(upd_o), 1);
            check($sformatf("R%0d row %0d fields", VECS[i].rq, i), pack_q(), pack_e(VECS[i]));
            @(negedge clk);
            check($sformatf("R2 quiet row %0d", i), int'(upd_o), 0);
        end

        // R3: pulse with valid low is ignored
        held = pack_q();
        apply_vec(VECS[0]);
        d_valid = 1'b0;
        d_idx = 5'd25;
        done_i = 1'b1;
        @(negedge clk);
        done_i = 1'b0;
        check("R3 upd_o", int'(upd_o), 0);
        check("R3 held", pack_q(), held);
        @(negedge clk);
        check("R3 held later", pack_q(), held);

        // R12: back-to-back accepted pulses
        apply_vec(VECS[3]);
        d_idx = 5'd14;
        done_i = 1'b1;
        @(negedge clk);
        check("R12 first upd", int'(upd_o), 1);
        check("R12 first next", int'(q_next), 15);
        d_idx = 5'd29;
        outcome_i = 3'd4;
        @(negedge clk);
        done_i = 1'b0;
        check("R12 second upd", int'(upd_o), 1);
        check("R12 second next", int'(q_next), 30);
        check("R12 second babble", int'(q_babble), 1);
        @(negedge clk);
        check("R12 release", int'(upd_o), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait (cycles >= 5000);
        total++;
        bad++;
        $display("FAIL watchdog R2 actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule